// File: doc/BRIEF.md
# Lane-wise SIMD Shuffle Unit

This unit rearranges 32-bit elements from two vector sources into a registered destination of up to 512 bits. The destination is split into 128-bit lanes. In each lane, an 8-bit immediate holds four 2-bit selectors. The two lower result elements of the lane are picked from the first source's four elements in that lane. The two upper result elements are picked from the second source's four elements in that lane. Element values are moved bit-for-bit, and no floating-point arithmetic is done.

Around the shuffle, the unit applies several optional controls:
- a vector-length code that chooses 128, 256 or 512 bits;
- a per-element write mask, with a merge or zero policy for masked elements;
- a broadcast of the second source's lowest element to every element position;
- a legacy 128-bit mode, in which the old destination bits above the first lane are kept.

A pipeline feeds one operation per `op_valid` pulse, together with the old destination value. One clock later it receives the result with `res_valid`.

Top module: `lane_shuffle_unit`

## Requirements
- R1: In every active lane, result element 0 equals the first-source element of that lane indexed by `sel_imm[1:0]`, and result element 1 equals the one indexed by `sel_imm[3:2]`.
- R2: In every active lane, result element 2 equals the second-source element of that lane indexed by `sel_imm[5:4]`, and result element 3 equals the one indexed by `sel_imm[7:6]`.
- R3: All active lanes use the same immediate. A selector value n picks bits [32n+31:32n] of its own lane and never reaches into another lane.
- R4: `vlen_code` 0 selects 128 bits (lane 0), 1 selects 256 bits (lanes 0–1), 2 selects 512 bits (lanes 0–3), and 3 is treated as 128 bits. Outside legacy mode, every destination bit above the selected length is zero.
- R5: With `mask_en`=1, an active element whose `elem_mask` bit is 0 keeps its `old_dst` value when `zero_mode`=0, and becomes zero when `zero_mode`=1. With `mask_en`=0, every active element takes the shuffled value.
- R6: With `bcast_b`=1 outside legacy mode, every element of the second source is replaced by second-source bits [31:0] before selection.
- R7: With `legacy`=1, only lane 0 is shuffled, `dst` bits [511:128] equal `old_dst` bits [511:128], and `mask_en`, `elem_mask`, `zero_mode`, `bcast_b` and `vlen_code` have no effect.
- R8: `dst` takes the result and `res_valid` is high in the clock cycle after `op_valid` is sampled high. `res_valid` is low after a cycle with `op_valid` low, and `dst` holds its value when no operation is taken.
- R9: A synchronous active-high `rst` clears `res_valid` and `dst` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| src_a | input | 512 | First source; feeds low pair of each lane |
| src_b | input | 512 | Second source; feeds high pair of each lane |
| sel_imm | input | 8 | Four 2-bit element selectors shared by all lanes |
| vlen_code | input | 2 | Vector length: 0=128, 1=256, 2=512, 3=128 |
| mask_en | input | 1 | Apply per-element write mask |
| elem_mask | input | 16 | Per-element write enable, bit j for element j |
| zero_mode | input | 1 | Masked elements: 1 zeroes, 0 keeps old value |
| bcast_b | input | 1 | Replicate second-source element 0 |
| legacy | input | 1 | Legacy 128-bit mode, upper bits preserved |
| old_dst | input | 512 | Previous destination value |
| res_valid | output | 1 | Result in `dst` is new this cycle |
| dst | output | 512 | Registered destination |

## Verification
Every result is due exactly one rising edge after the `op_valid` it belongs to. The bench drives each operation on a falling edge and samples `res_valid` and `dst` on the next falling edge, which is after the one capturing edge. It then lowers `op_valid`, waits one more edge, and checks that `res_valid` has dropped while `dst` is unchanged. This confirms the single-cycle pulse and the hold behaviour. The reset checks are made on the falling edge after a reset edge, so that the cleared state is the one observed.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;

  typedef enum logic [1:0] {
    VLEN_128  = 2'd0,
    VLEN_256  = 2'd1,
    VLEN_512  = 2'd2,
    VLEN_RSVD = 2'd3
  } vlen_e;

  // Number of 128-bit lanes enabled by a length code, clipped to the unit's lanes.
  function automatic int lanes_for(input logic [1:0] code, input int max_lanes);
    int n;
    case (vlen_e'(code))
      VLEN_256: n = 2;
      VLEN_512: n = 4;
      default:  n = 1;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/lsu_bcast.sv
module lsu_bcast #(
  parameter int ELEM_W    = 32,
  parameter int NUM_ELEMS = 16,
  localparam int VEC_W    = ELEM_W * NUM_ELEMS
) (
  input  logic [VEC_W-1:0] vec_in,
  input  logic             rep_en,
  output logic [VEC_W-1:0] vec_out
);

  genvar e;
  generate
    for (e = 0; e < NUM_ELEMS; e++) begin : g_elem
      assign vec_out[e*ELEM_W +: ELEM_W] = rep_en ? vec_in[ELEM_W-1:0]
                                                  : vec_in[e*ELEM_W +: ELEM_W];
    end
  endgenerate

endmodule

// File: rtl/lsu_lane_pick.sv
module lsu_lane_pick #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int IMM_W     = SEL_W * LANE_ELEMS
) (
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [LANE_W-1:0] lane_out
);

  localparam int HALF = LANE_ELEMS / 2;

  genvar s;
  generate
    for (s = 0; s < LANE_ELEMS; s++) begin : g_slot
      logic [SEL_W-1:0]  idx;
      logic [LANE_W-1:0] from;
      assign idx  = imm[s*SEL_W +: SEL_W];
      if (s < HALF) begin : g_lo
        assign from = lane_a;
      end else begin : g_hi
        assign from = lane_b;
      end
      assign lane_out[s*ELEM_W +: ELEM_W] = from[idx*ELEM_W +: ELEM_W];
    end
  endgenerate

endmodule

// File: rtl/lsu_mask_merge.sv
module lsu_mask_merge
  import lane_shuf_pkg::*;
#(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 4,
  localparam int NUM_ELEMS = LANE_ELEMS * NUM_LANES,
  localparam int VEC_W     = ELEM_W * NUM_ELEMS
) (
  input  logic [VEC_W-1:0]     shuf,
  input  logic [VEC_W-1:0]     old_val,
  input  logic [1:0]           vlen_code,
  input  logic                 mask_en,
  input  logic [NUM_ELEMS-1:0] elem_mask,
  input  logic                 zero_mode,
  input  logic                 legacy,
  output logic [VEC_W-1:0]     merged
);

  int n_lanes;

  always_comb begin
    n_lanes = legacy ? 1 : lanes_for(vlen_code, NUM_LANES);
    for (int j = 0; j < NUM_ELEMS; j++) begin
      if ((j / LANE_ELEMS) >= n_lanes) begin
        merged[j*ELEM_W +: ELEM_W] = legacy ? old_val[j*ELEM_W +: ELEM_W] : '0;
      end else if (!legacy && mask_en && !elem_mask[j]) begin
        merged[j*ELEM_W +: ELEM_W] = zero_mode ? '0 : old_val[j*ELEM_W +: ELEM_W];
      end else begin
        merged[j*ELEM_W +: ELEM_W] = shuf[j*ELEM_W +: ELEM_W];
      end
    end
  end

endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 4,
  localparam int NUM_ELEMS = LANE_ELEMS * NUM_LANES,
  localparam int LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int VEC_W     = LANE_W * NUM_LANES,
  localparam int IMM_W     = $clog2(LANE_ELEMS) * LANE_ELEMS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [VEC_W-1:0]     src_a,
  input  logic [VEC_W-1:0]     src_b,
  input  logic [IMM_W-1:0]     sel_imm,
  input  logic [1:0]           vlen_code,
  input  logic                 mask_en,
  input  logic [NUM_ELEMS-1:0] elem_mask,
  input  logic                 zero_mode,
  input  logic                 bcast_b,
  input  logic                 legacy,
  input  logic [VEC_W-1:0]     old_dst,
  output logic                 res_valid,
  output logic [VEC_W-1:0]     dst
);

  logic [VEC_W-1:0] b_eff;
  logic [VEC_W-1:0] shuf;
  logic [VEC_W-1:0] merged;

  lsu_bcast #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_bcast (
    .vec_in  (src_b),
    .rep_en  (bcast_b & ~legacy),
    .vec_out (b_eff)
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LANES; l++) begin : g_lane
      lsu_lane_pick #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS)) u_pick (
        .lane_a   (src_a[l*LANE_W +: LANE_W]),
        .lane_b   (b_eff[l*LANE_W +: LANE_W]),
        .imm      (sel_imm),
        .lane_out (shuf[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  lsu_mask_merge #(
    .ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS), .NUM_LANES(NUM_LANES)
  ) u_merge (
    .shuf      (shuf),
    .old_val   (old_dst),
    .vlen_code (vlen_code),
    .mask_en   (mask_en),
    .elem_mask (elem_mask),
    .zero_mode (zero_mode),
    .legacy    (legacy),
    .merged    (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      dst       <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) dst <= merged;
    end
  end

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int VEC_W     = 512,
  parameter int NUM_ELEMS = 16,
  parameter int IMM_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [VEC_W-1:0]     src_a,
  input logic [IMM_W-1:0]     sel_imm,
  input logic [1:0]           vlen_code,
  input logic                 mask_en,
  input logic [NUM_ELEMS-1:0] elem_mask,
  input logic                 zero_mode,
  input logic                 legacy,
  input logic [VEC_W-1:0]     old_dst,
  input logic                 res_valid,
  input logic [VEC_W-1:0]     dst
);

  AST_VALID_FOLLOWS_OP: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(op_valid)); // R8

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid); // R8

  AST_UPPER_ZEROED: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(legacy) && $past(vlen_code) != 2'd1 && $past(vlen_code) != 2'd2)
      |-> dst[VEC_W-1:128] == '0); // R4

  AST_LEGACY_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(legacy)) |-> dst[VEC_W-1:128] == $past(old_dst[VEC_W-1:128])); // R7

  AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(legacy) && $past(mask_en) && $past(zero_mode) && !$past(elem_mask[0]))
      |-> dst[31:0] == '0); // R5

  AST_ELEM0_FROM_A: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !($past(mask_en) && !$past(elem_mask[0])) && $past(sel_imm[1:0]) == 2'd0)
      |-> dst[31:0] == $past(src_a[31:0])); // R1

endmodule

bind lane_shuffle_unit lsu_checker #(
  .VEC_W(VEC_W), .NUM_ELEMS(NUM_ELEMS), .IMM_W(IMM_W)
) u_lsu_checker (
  .clk(clk), .rst(rst), .op_valid(op_valid), .src_a(src_a), .sel_imm(sel_imm),
  .vlen_code(vlen_code), .mask_en(mask_en), .elem_mask(elem_mask),
  .zero_mode(zero_mode), .legacy(legacy), .old_dst(old_dst),
  .res_valid(res_valid), .dst(dst)
);

// File: tb/test_lane_shuffle_unit.sv
module test_lane_shuffle_unit;

  localparam int NV = 10;
  // {imm[29:22], vlen[21:20], mask_en[19], mask[18:3], zero[2], bcast[1], legacy[0]}
  localparam logic [29:0] VEC [NV] = '{
    {8'hE4, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {8'h1B, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {8'h4E, 2'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {8'hFF, 2'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {8'h00, 2'd2, 1'b1, 16'hA5A5, 1'b0, 1'b0, 1'b0},
    {8'hB1, 2'd2, 1'b1, 16'h5A3C, 1'b1, 1'b0, 1'b0},
    {8'h72, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
    {8'hD8, 2'd2, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b1},
    {8'h39, 2'd2, 1'b1, 16'hF0F0, 1'b0, 1'b1, 1'b0},
    {8'hC6, 2'd0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [511:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [7:0]   sel_imm = '0;
  logic [1:0]   vlen_code = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast_b = 1'b0, legacy = 1'b0;
  logic [15:0]  elem_mask = '0;
  logic         res_valid;
  logic [511:0] dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_shuffle_unit i_lane_shuffle_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .src_a(src_a), .src_b(src_b),
    .sel_imm(sel_imm), .vlen_code(vlen_code), .mask_en(mask_en),
    .elem_mask(elem_mask), .zero_mode(zero_mode), .bcast_b(bcast_b),
    .legacy(legacy), .old_dst(old_dst), .res_valid(res_valid), .dst(dst)
  );

  function automatic string req_tag(int v);
    case (v)
      0: return "R1 R2";
      1, 2: return "R3 R4";
      3: return "R4";
      4, 5: return "R5";
      6, 8: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference result built from the requirements.
  function automatic logic [511:0] expect_of(logic [511:0] a, logic [511:0] b,
      logic [511:0] od, logic [7:0] imm, logic [1:0] vl, logic me,
      logic [15:0] mk, logic zm, logic bc, logic lg);
    logic [511:0] r;
    logic [31:0]  bb [16];
    int nl;
    for (int k = 0; k < 16; k++) bb[k] = (bc && !lg) ? b[31:0] : b[k*32 +: 32];
    nl = lg ? 1 : (vl == 2'd1 ? 2 : (vl == 2'd2 ? 4 : 1));
    for (int k = 0; k < 16; k++) begin
      int ln = k / 4;
      int slot = k % 4;
      int sel = imm[slot*2 +: 2];
      logic [31:0] v;
      v = (slot < 2) ? a[(ln*4 + sel)*32 +: 32] : bb[ln*4 + sel];
      if (ln >= nl) v = lg ? od[k*32 +: 32] : 32'h0;
      else if (!lg && me && !mk[k]) v = zm ? 32'h0 : od[k*32 +: 32];
      r[k*32 +: 32] = v;
    end
    return r;
  endfunction

  task automatic check512(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dst actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic fill(int seed);
    for (int k = 0; k < 16; k++) begin
      src_a[k*32 +: 32]   = 32'hAA00_0000 + (seed << 8) + k;
      src_b[k*32 +: 32]   = 32'hBB00_0000 + (seed << 8) + k;
      old_dst[k*32 +: 32] = 32'hCC00_0000 + (seed << 8) + k;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp, held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R9 reset res_valid", res_valid, 1'b0);
    check512("R9 reset dst", dst, '0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      fill(v + 1);
      {sel_imm, vlen_code, mask_en, elem_mask, zero_mode, bcast_b, legacy} = VEC[v];
      op_valid = 1'b1;
      exp = expect_of(src_a, src_b, old_dst, sel_imm, vlen_code, mask_en,
                      elem_mask, zero_mode, bcast_b, legacy);
      @(negedge clk);
      op_valid = 1'b0;
      check1({req_tag(v), " R8 valid"}, res_valid, 1'b1);
      check512(req_tag(v), dst, exp);
    end

    // R8: no operation -> pulse ends and dst holds
    held = dst;
    src_a = ~src_a;
    @(negedge clk);
    check1("R8 valid drops", res_valid, 1'b0);
    check512("R8 dst holds", dst, held);

    // R3: selector 1 in every slot picks bits [63:32] of each lane
    fill(40);
    sel_imm = 8'h55; vlen_code = 2'd2; mask_en = 1'b0; bcast_b = 1'b0; legacy = 1'b0;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check512("R3 lane3 elem0", {480'h0, dst[415:384]}, {480'h0, src_a[447:416]});
    check512("R3 lane3 elem3", {480'h0, dst[511:480]}, {480'h0, src_b[447:416]});

    // R6: broadcast with 128-bit length, every upper selector reads b[31:0]
    fill(41);
    sel_imm = 8'hC0; vlen_code = 2'd0; bcast_b = 1'b1;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check512("R6 bcast elem3", {480'h0, dst[127:96]}, {480'h0, src_b[31:0]});
    bcast_b = 1'b0;

    // R9: reset after a result clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check1("R9 reset valid", res_valid, 1'b0);
    check512("R9 reset dst cleared", dst, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule